// File: doc/BRIEF.md
# Prioritized Interrupt Request Gate

This block sits between the external interrupt pins and a processor core. Every clock it captures the active-low request line together with a four-bit priority code, so that the request and its code are always taken from the same edge. When the core reports an instruction boundary, the captured code is compared with the four-bit interrupt mask from the status register. A request whose code is numerically at or below the mask is taken: the block raises a valid flag and presents the accepted level to the core.

The accepted level leaves the block on a valid/ready pair. `take_valid` stays high and `take_level` stays fixed until the core answers with `take_ready`. The core may hold `take_ready` low for as long as it likes, and no new request disturbs the pending one in that time. `take_ready` while nothing is pending has no effect.

A request that fails the comparison is not stored. It is captured again on every clock while the line stays low, and it is tried again at every later boundary. It is taken as soon as software raises the mask far enough.

Top module: `irq_gate`

## Requirements
- R1: While `rst_n` is low, and after it is released, `take_valid` is 0 and `take_level` is 0 until a request is taken.
- R2: `intreq_n` and `icode` are registered together on every rising edge. A boundary that is high during the following cycle judges that captured pair, and `take_valid` rises after that next edge with `take_level` equal to the captured code. `icode[3]` is the most significant bit of the code.
- R3: A captured request is taken when the code, read as an unsigned number, is less than or equal to `mask`. Code 0 is the highest priority and code 15 the lowest.
- R4: A request whose code is above the mask is not taken and leaves no state behind. While `intreq_n` stays low it is judged again at every later boundary, and it is taken once the mask is at or above its code.
- R5: Nothing is taken in a cycle where `instr_boundary` is low.
- R6: A captured `intreq_n` that is high (no request) is never taken, whatever the code and the mask.
- R7: While `take_valid` is high and `take_ready` is low, `take_valid` stays high and `take_level` stays unchanged, whatever the request, code, mask and boundary inputs do.
- R8: `take_valid` falls on the edge after a cycle in which `take_valid` and `take_ready` are both high. A boundary in that same cycle is ignored, so the next request can be taken no earlier than the following boundary.
- R9: `take_ready` while `take_valid` is low has no effect.
- R10: The mask is read in the boundary cycle itself, so a mask change made during that cycle decides the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| intreq_n | input | 1 | External interrupt request, active low |
| icode | input | 4 | Request priority code, bit 3 is the MSB, 0 is the highest priority |
| mask | input | 4 | Interrupt mask from the status register |
| instr_boundary | input | 1 | One-cycle pulse from the core at each instruction boundary |
| take_valid | output | 1 | An accepted interrupt is pending |
| take_level | output | 4 | Code of the accepted interrupt |
| take_ready | input | 1 | Core consumes the pending interrupt |

## Verification
Two functions can fall in the same cycle: the core completing the handshake on a pending interrupt, and a new instruction boundary that would judge another request that is still waiting. The bench keeps a second request low behind a pending one and raises `take_ready` and `instr_boundary` together. It judges that `take_valid` drops and stays low through the following cycle, and that the waiting request is taken only at the next separate boundary. A mask change made inside the boundary cycle is a second case of this kind, and the outcome it produces is checked against the new mask.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  localparam int unsigned DEF_CODE_W = 4;

  typedef enum logic {
    GATE_IDLE = 1'b0,
    GATE_PEND = 1'b1
  } gate_state_e;
endpackage

// File: rtl/irq_sampler.sv
module irq_sampler #(
  parameter int unsigned CODE_W = irq_gate_pkg::DEF_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              intreq_n,
  input  logic [CODE_W-1:0] icode,
  output logic              smp_req,
  output logic [CODE_W-1:0] smp_code
);
  // request and code share one register stage so the compare sees one edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_req  <= 1'b0;
      smp_code <= '0;
    end else begin
      smp_req  <= ~intreq_n;
      smp_code <= icode;
    end
  end
endmodule

// File: rtl/irq_prio_cmp.sv
module irq_prio_cmp #(
  parameter int unsigned CODE_W = irq_gate_pkg::DEF_CODE_W
) (
  input  logic              smp_req,
  input  logic [CODE_W-1:0] smp_code,
  input  logic [CODE_W-1:0] mask,
  output logic              grant
);
  // lower code means higher priority; equal to the mask still passes
  always_comb begin
    grant = smp_req && (smp_code <= mask);
  end
endmodule

// File: rtl/irq_hold.sv
module irq_hold #(
  parameter int unsigned CODE_W = irq_gate_pkg::DEF_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary,
  input  logic              grant,
  input  logic [CODE_W-1:0] smp_code,
  input  logic              take_ready,
  output logic              take_valid,
  output logic [CODE_W-1:0] take_level
);
  import irq_gate_pkg::*;

  gate_state_e              state_q, state_d;
  logic [CODE_W-1:0]        level_q, level_d;

  always_comb begin
    state_d = state_q;
    level_d = level_q;
    unique case (state_q)
      GATE_IDLE: begin
        if (boundary && grant) begin
          state_d = GATE_PEND;
          level_d = smp_code;
        end
      end
      GATE_PEND: begin
        // the handshake wins; a boundary in the same cycle is not looked at
        if (take_ready) begin
          state_d = GATE_IDLE;
        end
      end
      default: state_d = GATE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GATE_IDLE;
      level_q <= '0;
    end else begin
      state_q <= state_d;
      level_q <= level_d;
    end
  end

  assign take_valid = (state_q == GATE_PEND);
  assign take_level = level_q;
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int unsigned CODE_W = irq_gate_pkg::DEF_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              intreq_n,
  input  logic [CODE_W-1:0] icode,
  input  logic [CODE_W-1:0] mask,
  input  logic              instr_boundary,
  output logic              take_valid,
  output logic [CODE_W-1:0] take_level,
  input  logic              take_ready
);
  logic              smp_req;
  logic [CODE_W-1:0] smp_code;
  logic              grant;

  irq_sampler #(.CODE_W(CODE_W)) u_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .intreq_n (intreq_n),
    .icode    (icode),
    .smp_req  (smp_req),
    .smp_code (smp_code)
  );

  irq_prio_cmp #(.CODE_W(CODE_W)) u_cmp (
    .smp_req  (smp_req),
    .smp_code (smp_code),
    .mask     (mask),
    .grant    (grant)
  );

  irq_hold #(.CODE_W(CODE_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .boundary   (instr_boundary),
    .grant      (grant),
    .smp_code   (smp_code),
    .take_ready (take_ready),
    .take_valid (take_valid),
    .take_level (take_level)
  );
endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk #(
  parameter int unsigned CODE_W = irq_gate_pkg::DEF_CODE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              intreq_n,
  input logic [CODE_W-1:0] icode,
  input logic [CODE_W-1:0] mask,
  input logic              instr_boundary,
  input logic              take_valid,
  input logic [CODE_W-1:0] take_level,
  input logic              take_ready
);
  // R1: outputs are clear while reset is held
  always_comb begin
    if (!rst_n) begin
      a_r1_reset_clear: assert (!take_valid && take_level == '0);
    end
  end

  // R7: pending interrupt is held stable until the core answers
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && !take_ready) |=> (take_valid && $stable(take_level)));

  // R8: handshake drops the flag on the next edge
  a_r8_handshake_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && take_ready) |=> !take_valid);

  // R5: an acceptance needs a boundary in the deciding cycle
  a_r5_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take_valid) |-> $past(instr_boundary));

  // R3 and R10: the taken level never exceeds the mask of the deciding cycle
  a_r3_level_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take_valid) |-> (take_level <= $past(mask)));

  // R2 and R6: the taken level is the code captured one edge earlier with a live request
  a_r2_coherent_sample: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take_valid) |-> (take_level == $past(icode, 2) && !$past(intreq_n, 2)));
endmodule

bind irq_gate irq_gate_chk #(.CODE_W(CODE_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .intreq_n       (intreq_n),
  .icode          (icode),
  .mask           (mask),
  .instr_boundary (instr_boundary),
  .take_valid     (take_valid),
  .take_level     (take_level),
  .take_ready     (take_ready)
);

// File: tb/irq_gate_test.sv
module irq_gate_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       intreq_n = 1'b1;
  logic [3:0] icode = 4'd0;
  logic [3:0] mask = 4'd0;
  logic       instr_boundary = 1'b0;
  logic       take_ready = 1'b0;
  logic       take_valid;
  logic [3:0] take_level;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_gate uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .intreq_n       (intreq_n),
    .icode          (icode),
    .mask           (mask),
    .instr_boundary (instr_boundary),
    .take_valid     (take_valid),
    .take_level     (take_level),
    .take_ready     (take_ready)
  );

  // vector: {req_n, code, mask, expected take}
  localparam int NV = 14;
  localparam logic [9:0] VEC [NV] = '{
    {1'b0, 4'd0,  4'd0,  1'b1},
    {1'b0, 4'd1,  4'd0,  1'b0},
    {1'b0, 4'd15, 4'd15, 1'b1},
    {1'b0, 4'd15, 4'd14, 1'b0},
    {1'b0, 4'd7,  4'd7,  1'b1},
    {1'b0, 4'd8,  4'd7,  1'b0},
    {1'b0, 4'd8,  4'd9,  1'b1},
    {1'b0, 4'd3,  4'd12, 1'b1},
    {1'b0, 4'd12, 4'd3,  1'b0},
    {1'b1, 4'd0,  4'd15, 1'b0},
    {1'b1, 4'd5,  4'd5,  1'b0},
    {1'b0, 4'd10, 4'd10, 1'b1},
    {1'b0, 4'd4,  4'd2,  1'b0},
    {1'b0, 4'd2,  4'd4,  1'b1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // capture on one edge, decide on the next, then retire any acceptance
  task automatic run_case(input logic rq_n, input logic [3:0] c, input logic [3:0] m,
                          input bit exp, input string req);
    intreq_n = rq_n; icode = c; mask = m;
    tick();
    instr_boundary = 1'b1;
    tick();
    instr_boundary = 1'b0;
    chk(take_valid == exp, req, take_valid, exp);
    if (exp) begin
      chk(take_level == c, req, take_level, c);
      take_ready = 1'b1;
      tick();
      take_ready = 1'b0;
      chk(take_valid == 1'b0, "R8", take_valid, 0);
    end
    intreq_n = 1'b1;
    tick();
  endtask

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: reset state, with inputs that would otherwise be taken
    intreq_n = 1'b0; icode = 4'd0; mask = 4'd15; instr_boundary = 1'b1;
    tick(); tick();
    chk(take_valid == 1'b0, "R1", take_valid, 0);
    chk(take_level == 4'd0, "R1", take_level, 0);
    instr_boundary = 1'b0; intreq_n = 1'b1;
    rst_n = 1'b1;
    tick();
    chk(take_valid == 1'b0 && take_level == 4'd0, "R1", take_valid, 0);

    // table walk (R2, R3, R6)
    for (int i = 0; i < NV; i++) begin
      run_case(VEC[i][9], VEC[i][8:5], VEC[i][4:1], VEC[i][0],
               VEC[i][9] ? "R6" : "R3");
    end

    // full sweep of code against mask (R3)
    for (int c = 0; c < 16; c++) begin
      for (int m = 0; m < 16; m++) begin
        run_case(1'b0, c[3:0], m[3:0], (c <= m), "R3");
      end
    end

    // R5: request present for many cycles but no boundary
    intreq_n = 1'b0; icode = 4'd1; mask = 4'd9;
    for (int k = 0; k < 5; k++) tick();
    chk(take_valid == 1'b0, "R5", take_valid, 0);

    // R2: code changes between capture and boundary; captured code is used
    icode = 4'd6;
    tick();
    icode = 4'd2;
    instr_boundary = 1'b1;
    tick();
    instr_boundary = 1'b0;
    chk(take_valid == 1'b1 && take_level == 4'd6, "R2", take_level, 6);

    // R7: held without ready while inputs move and boundaries come
    for (int k = 0; k < 4; k++) begin
      icode = 4'(k); mask = 4'd15; instr_boundary = 1'b1;
      tick();
      instr_boundary = 1'b0;
      tick();
    end
    chk(take_valid == 1'b1, "R7", take_valid, 1);
    chk(take_level == 4'd6, "R7", take_level, 6);

    // R8: ready and boundary together, with another request waiting
    icode = 4'd3; mask = 4'd15;
    tick();
    take_ready = 1'b1; instr_boundary = 1'b1;
    tick();
    take_ready = 1'b0; instr_boundary = 1'b0;
    chk(take_valid == 1'b0, "R8", take_valid, 0);
    tick();
    chk(take_valid == 1'b0, "R8", take_valid, 0);
    instr_boundary = 1'b1;
    tick();
    instr_boundary = 1'b0;
    chk(take_valid == 1'b1 && take_level == 4'd3, "R8", take_level, 3);
    take_ready = 1'b1;
    tick();
    take_ready = 1'b0;
    intreq_n = 1'b1;

    // R9: ready while idle, then a request is taken normally
    take_ready = 1'b1;
    tick(); tick();
    chk(take_valid == 1'b0, "R9", take_valid, 0);
    intreq_n = 1'b0; icode = 4'd5; mask = 4'd5;
    tick();
    instr_boundary = 1'b1;
    tick();
    instr_boundary = 1'b0;
    chk(take_valid == 1'b1 && take_level == 4'd5, "R9", take_level, 5);
    tick();
    chk(take_valid == 1'b0, "R9", take_valid, 0);
    take_ready = 1'b0;
    intreq_n = 1'b1;
    tick();

    // R4: rejected request retried later after the mask is raised
    intreq_n = 1'b0; icode = 4'd9; mask = 4'd5;
    tick();
    instr_boundary = 1'b1;
    tick();
    instr_boundary = 1'b0;
    chk(take_valid == 1'b0, "R4", take_valid, 0);
    tick(); tick();
    mask = 4'd12;
    instr_boundary = 1'b1;
    tick();
    instr_boundary = 1'b0;
    chk(take_valid == 1'b1 && take_level == 4'd9, "R4", take_level, 9);
    take_ready = 1'b1;
    tick();
    take_ready = 1'b0;

    // R10: mask changes inside the boundary cycle
    icode = 4'd8; mask = 4'd15;
    tick();
    instr_boundary = 1'b1;
    #1 mask = 4'd7;
    tick();
    instr_boundary = 1'b0;
    chk(take_valid == 1'b0, "R10", take_valid, 0);
    mask = 4'd0;
    tick();
    instr_boundary = 1'b1;
    #1 mask = 4'd8;
    tick();
    instr_boundary = 1'b0;
    chk(take_valid == 1'b1 && take_level == 4'd8, "R10", take_level, 8);
    take_ready = 1'b1;
    tick();
    take_ready = 1'b0;
    intreq_n = 1'b1;
    tick();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule